// File: doc/BRIEF.md
# Prescaled Timer/Counter with External Count Input

An 8-bit up-counter whose increment event comes from one of several sources chosen by a 3-bit select field. The sources are a free-running power-of-two prescaler, the system clock itself, or a synchronised edge of an external count pin. The select code also provides a stop setting, so the same field acts as the timer's enable. When the counter rolls over from its all-ones value to zero, it sets an overflow flag. That flag, gated by a local enable and a chip-wide interrupt enable, drives an interrupt request.

Software reaches the block through a plain single-cycle write strobe with a 2-bit address. The held state is always visible on output ports, so there is no read path and no handshake. The flag is cleared in two ways: by writing a one to it, or by an acknowledge pulse from the interrupt controller.

Top module: `prescaled_event_counter`

## Requirements
- R1: After reset, the select field, counter, overflow flag and overflow enable all read zero, and the interrupt request is low.
- R2: Select code 1 increments the counter on every clock. Codes 2, 3, 4 and 5 increment it once every 2^SH_D1, 2^SH_D2, 2^SH_D3 and 2^SH_D4 clocks respectively. After a change from the stop code, the first increment lands exactly one full period after the edge that wrote the select.
- R3: Select code 6 counts falling edges of `ext_pin` and code 7 counts rising edges, once per edge. The other polarity has no effect. A pin change made between clock edges shows in the counter at the third rising clock edge.
- R4: Select code 0 holds the counter at its value and keeps the prescaler cleared.
- R5: An increment from all-ones to zero sets the overflow flag.
- R6: `irq_o` is high exactly when the overflow flag, the overflow enable and `global_ie` are all high.
- R7: Writing 1 to bit 0 at address 2 clears the flag, and writing 0 there leaves it unchanged. An `irq_ack` pulse also clears it. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R8: A software write to the counter in the same cycle as an increment stores the written value. That cycle sets no overflow flag, even from all-ones.
- R9: The address map is: 0 = select (bits 2:0, upper data bits ignored), 1 = counter, 2 = flag clear (bit 0), 3 = overflow enable (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Write data |
| ext_pin | input | 1 | External count pin, asynchronous |
| global_ie | input | 1 | Chip-wide interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sel_o | output | 3 | Current count-source select |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Overflow flag |
| ovf_ie_o | output | 1 | Overflow interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a counter width of 8 and tap shifts of 1, 2, 3 and 4, so the four divided sources tick every 2, 4, 8 and 16 clocks. At that spacing, randomly drawn windows span several tap periods and reach wraps from random start values within a few dozen cycles. Exact first-tick timing after a restart, and the same-cycle collisions of write against increment and of wrap against clear, stay cheap to reach at this scale.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [2:0] {
    SRC_STOP   = 3'd0,
    SRC_CLK    = 3'd1,
    SRC_DIV_A  = 3'd2,
    SRC_DIV_B  = 3'd3,
    SRC_DIV_C  = 3'd4,
    SRC_DIV_D  = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } pec_src_e;

  localparam logic [1:0] ADR_SRC  = 2'd0;
  localparam logic [1:0] ADR_CNT  = 2'd1;
  localparam logic [1:0] ADR_FLAG = 2'd2;
  localparam logic [1:0] ADR_IE   = 2'd3;
  localparam int NUM_TAPS = 4;
endpackage

// File: rtl/pec_prescaler.sv
module pec_prescaler #(
  parameter int SH_D1 = 3,
  parameter int SH_D2 = 6,
  parameter int SH_D3 = 8,
  parameter int SH_D4 = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  output logic [pec_pkg::NUM_TAPS-1:0] tap_o
);
  localparam int PRE_W = SH_D4;
  localparam int SHV [pec_pkg::NUM_TAPS] = '{SH_D1, SH_D2, SH_D3, SH_D4};

  logic [PRE_W-1:0] pre_q;

  // free-running divider, parked at zero while the counter is stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < pec_pkg::NUM_TAPS; g++) begin : g_tap
    assign tap_o[g] = run && (&pre_q[SHV[g]-1:0]);
  end

  // R2: the first cycle after leaving stop never carries a divided tick
  a_r2_no_early_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (tap_o == '0));
endmodule

// File: rtl/pec_edge_sync.sv
module pec_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;

  // R3: one count pulse per edge, never two in a row
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/prescaled_event_counter.sv
module prescaled_event_counter #(
  parameter int CNT_W = 8,
  parameter int SH_D1 = 3,
  parameter int SH_D2 = 6,
  parameter int SH_D3 = 8,
  parameter int SH_D4 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_pin,
  input  logic             global_ie,
  input  logic             irq_ack,
  output logic [2:0]       sel_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             ovf_ie_o,
  output logic             irq_o
);
  import pec_pkg::*;

  pec_src_e               src_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   ovf_q, ie_q;
  logic [NUM_TAPS-1:0]    taps;
  logic                   pin_rise, pin_fall, tick;
  logic                   wr_src, wr_cnt, wr_flag, wr_ie, wrap, flag_clr;

  assign wr_src  = wr_en && (wr_addr == ADR_SRC);
  assign wr_cnt  = wr_en && (wr_addr == ADR_CNT);
  assign wr_flag = wr_en && (wr_addr == ADR_FLAG);
  assign wr_ie   = wr_en && (wr_addr == ADR_IE);

  pec_prescaler #(.SH_D1(SH_D1), .SH_D2(SH_D2), .SH_D3(SH_D3), .SH_D4(SH_D4)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(src_q != SRC_STOP), .tap_o(taps));

  pec_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_o(pin_rise), .fall_o(pin_fall));

  always_comb begin
    unique case (src_q)
      SRC_STOP:     tick = 1'b0;
      SRC_CLK:      tick = 1'b1;
      SRC_DIV_A:    tick = taps[0];
      SRC_DIV_B:    tick = taps[1];
      SRC_DIV_C:    tick = taps[2];
      SRC_DIV_D:    tick = taps[3];
      SRC_PIN_FALL: tick = pin_fall;
      SRC_PIN_RISE: tick = pin_rise;
      default:      tick = 1'b0;
    endcase
  end

  assign wrap     = tick && (&cnt_q) && !wr_cnt;
  assign flag_clr = (wr_flag && wr_data[0]) || irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_STOP;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_src) src_q <= pec_src_e'(wr_data[2:0]);
      if (wr_ie)  ie_q  <= wr_data[0];
      if (wr_cnt)    cnt_q <= wr_data;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (wrap)          ovf_q <= 1'b1;
      else if (flag_clr) ovf_q <= 1'b0;
    end
  end

  assign sel_o    = src_q;
  assign cnt_o    = cnt_q;
  assign ovf_o    = ovf_q;
  assign ovf_ie_o = ie_q;
  assign irq_o    = ovf_q & ie_q & global_ie;

  // R4: stopped counter does not move unless software writes it
  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_STOP && !wr_cnt) |=> $stable(cnt_q));
  // R8: written value beats any increment
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data)));
  // R5: rollover leaves the flag set and the counter at zero
  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_q) && !wr_cnt) |=> (ovf_q && cnt_q == '0));
  // R7: acknowledge without a coinciding wrap clears the flag
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wrap) |=> !ovf_q);
endmodule

// File: tb/sim_prescaled_event_counter.sv
module sim_prescaled_event_counter;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, ext_pin = 1'b0, global_ie = 1'b0, irq_ack = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0] sel_o;
  logic [CW-1:0] cnt_o;
  logic ovf_o, ovf_ie_o, irq_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prescaled_event_counter #(.CNT_W(CW), .SH_D1(1), .SH_D2(2), .SH_D3(3), .SH_D4(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_pin(ext_pin), .global_ie(global_ie), .irq_ack(irq_ack), .sel_o(sel_o),
    .cnt_o(cnt_o), .ovf_o(ovf_o), .ovf_ie_o(ovf_ie_o), .irq_o(irq_o));

  function automatic int period_of(int s);
    return (s == 1) ? 1 : (1 << (s - 1));
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [CW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic prime(logic [CW-1:0] start);
    reg_wr(2'd0, 8'd0);
    reg_wr(2'd1, start);
    reg_wr(2'd2, 8'd1);
  endtask

  task automatic run_timer(int s, logic [CW-1:0] start, int n);
    int total;
    prime(start);
    reg_wr(2'd0, CW'(s));
    repeat (n) @(negedge clk);
    total = int'(start) + n / period_of(s);
    check("R2 count", int'(cnt_o), total % 256);
    check("R5 flag", int'(ovf_o), int'(total > 255));
  endtask

  task automatic run_pin(int s, logic [CW-1:0] start, int k);
    int total;
    prime(start);
    reg_wr(2'd0, CW'(s));
    for (int i = 0; i < k; i++) begin
      ext_pin = 1'b1; repeat (4) @(negedge clk);
      ext_pin = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    total = int'(start) + k;
    check("R3 pin count", int'(cnt_o), total % 256);
    check("R5 pin flag", int'(ovf_o), int'(total > 255));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sel", int'(sel_o), 0);
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 flag", int'(ovf_o), 0);
    check("R1 ie", int'(ovf_ie_o), 0);
    check("R1 irq", int'(irq_o), 0);

    // R9 select keeps only bits 2:0
    reg_wr(2'd0, 8'hF8);
    check("R9 sel mask", int'(sel_o), 0);

    // R4 stop freezes
    reg_wr(2'd1, 8'h33);
    repeat (20) @(negedge clk);
    check("R4 frozen", int'(cnt_o), 8'h33);

    // R2 exact first tick for divide-by-8 (select 4)
    prime(8'd10);
    reg_wr(2'd0, 8'd4);
    repeat (7) @(negedge clk);
    check("R2 before first tick", int'(cnt_o), 10);
    @(negedge clk);
    check("R2 first tick", int'(cnt_o), 11);
    // R4 stop again, prescaler restarts cleanly
    reg_wr(2'd0, 8'd0);
    repeat (5) @(negedge clk);
    check("R4 stop after run", int'(cnt_o), 11);

    // R2/R5 random timer windows
    for (int i = 0; i < 40; i++) begin
      int s;
      s = 1 + int'($urandom_range(4));
      v = (i % 3 == 0) ? CW'(240 + $urandom_range(15)) : CW'($urandom);
      run_timer(s, v, int'($urandom_range(60)));
    end

    // R3 latency on rising edges, falling ignored
    prime(8'd5);
    reg_wr(2'd0, 8'd7);
    ext_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 rise not yet", int'(cnt_o), 5);
    @(negedge clk);
    check("R3 rise counted", int'(cnt_o), 6);
    ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 fall ignored in rise mode", int'(cnt_o), 6);
    // falling mode ignores rising edge
    reg_wr(2'd0, 8'd6);
    ext_pin = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 rise ignored in fall mode", int'(cnt_o), 6);
    ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 fall counted", int'(cnt_o), 7);

    for (int i = 0; i < 8; i++) begin
      v = (i % 2 == 0) ? CW'(250 + $urandom_range(5)) : CW'($urandom);
      run_pin(6 + (i % 2), v, 1 + int'($urandom_range(7)));
    end

    // R8 write beats increment, and blocks wrap
    prime(8'hFE);
    reg_wr(2'd0, 8'd1);
    reg_wr(2'd1, 8'h10);
    check("R8 write wins", int'(cnt_o), 8'h10);
    check("R8 no flag on write over FF", int'(ovf_o), 0);
    @(negedge clk);
    check("R8 counting resumes", int'(cnt_o), 8'h11);

    // R7 wrap and ack in the same cycle: set wins
    prime(8'hFF);
    reg_wr(2'd0, 8'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R7 set beats ack", int'(ovf_o), 1);
    check("R5 wrapped to zero", int'(cnt_o), 0);
    reg_wr(2'd0, 8'd0);

    // R6 gating
    reg_wr(2'd3, 8'd1);
    check("R9 ie bit", int'(ovf_ie_o), 1);
    check("R6 irq needs global", int'(irq_o), 0);
    global_ie = 1'b1;
    @(negedge clk);
    check("R6 irq all set", int'(irq_o), 1);
    reg_wr(2'd3, 8'd0);
    check("R6 irq needs local enable", int'(irq_o), 0);
    reg_wr(2'd3, 8'd1);
    // R7 write zero has no effect, write one clears
    reg_wr(2'd2, 8'd0);
    check("R7 write zero kept flag", int'(ovf_o), 1);
    reg_wr(2'd2, 8'd1);
    check("R7 w1c", int'(ovf_o), 0);
    check("R6 irq drops", int'(irq_o), 0);
    // R7 ack clears
    prime(8'hFF);
    reg_wr(2'd0, 8'd1);
    reg_wr(2'd0, 8'd0);
    check("R5 flag before ack", int'(ovf_o), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R7 ack clears", int'(ovf_o), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule